// File: doc/BRIEF.md
# Radio Transceiver Configuration Sequencer

This block sets up a 2.4 GHz packet-radio transceiver over a four-wire serial link. A one-cycle start pulse launches the sequence. The mode input, sampled on that pulse, selects either the transmit or the receive profile. The sequencer first pulls the radio enable line low. It then issues a fixed series of register writes, each in its own chip-select window, with the serial clock idling low and data sent most significant bit first. At the end it raises the radio enable line and pulses done.

In transmit mode one of the transactions carries a 32-byte payload. The payload arrives on a byte-wide valid/ready stream. A byte is consumed on a clock edge where both valid and ready are high. Ready is only raised while the sequencer is waiting for a payload byte inside the payload transaction. While valid stays low, the serial clock is paused and chip select stays asserted, so the stream can apply back-pressure for any length of time without splitting the frame.

The radio returns a status byte as the first byte of every transaction. The sequencer captures it and presents it with a one-cycle qualifier.

Top module: `radio_cfg_seq`

## Requirements
- R1: After reset the outputs are csn_o=1, sclk_o=0, ce_o=0, busy_o=0, done_o=0, pl_ready_o=0 and status_vld_o=0.
- R2: The serial link uses mode 0. sclk_o idles low and stays low while csn_o is high. mosi_o changes only while sclk_o is low. Each byte is sent most significant bit first. miso_i is sampled on the rising serial clock edge.
- R3: Within a byte, consecutive rising edges of sclk_o are exactly CLK_DIV system clocks apart. CLK_DIV is an even value of at least 2.
- R4: Every transaction lies inside one window where csn_o is low. Between two transactions, and before the first one, csn_o stays high for at least CLK_DIV system clocks.
- R5: The command byte of a register write is 0x20 OR'd with the 5-bit register address. The payload write uses command 0xA0.
- R6: In transmit mode (mode_tx_i=1) the transactions are, in order: 0x10 with the address, 0x0A with the address, the payload write, 0x01=0x01, 0x02=0x01, 0x04=0x0A, 0x05=0x40, 0x06=0x07, and last 0x00=0x0E.
- R7: In receive mode (mode_tx_i=0) the transactions are, in order: 0x0A with the address, 0x01=0x01, 0x02=0x01, 0x05=0x40, 0x11=PAYLOAD_LEN (0x20), 0x06=0x07, and last 0x00=0x0F.
- R8: Each address write carries ADDR_LEN data bytes, each equal to ADDR_BYTE. The defaults are 5 and 0xE7.
- R9: The payload write carries PAYLOAD_LEN data bytes (32 by default), taken from pl_data_i in stream order. A byte moves when pl_valid_i and pl_ready_o are both high. Holding pl_valid_i low stalls the frame with csn_o kept low.
- R10: The first byte received in each transaction appears on status_o, with status_vld_o high for one cycle while csn_o is still low.
- R11: ce_o is low from the start pulse until the final write has completed. ce_o then rises in the same cycle as a one-cycle done_o pulse, and busy_o is high from the cycle after start until that cycle.
- R12: A start pulse that arrives while busy_o is high has no effect. The running sequence continues unchanged, and only one done pulse follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| mode_tx_i | input | 1 | 1 selects the transmit profile, 0 selects the receive profile; sampled on start |
| pl_data_i | input | 8 | Payload stream data |
| pl_valid_i | input | 1 | Payload stream valid |
| pl_ready_o | output | 1 | Payload stream ready |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the radio |
| miso_i | input | 1 | Serial data from the radio |
| csn_o | output | 1 | Active-low chip select |
| ce_o | output | 1 | Radio enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Last captured status byte |
| status_vld_o | output | 1 | One-cycle qualifier for status_o |

## Verification
The properties take it that start_i is a single-cycle pulse and that the stream inputs are driven synchronously to clk. They make no assumption about miso_i, which only feeds captured data. The bench's radio model changes miso_i only on falling serial clock edges and while chip select falls. It drives the payload stream on falling system clock edges with a repeating pattern of stalls. In the middle of a transmit run it injects a start pulse with the opposite mode, to confirm that the pulse is ignored.

// File: rtl/radio_cfg_pkg.sv
package radio_cfg_pkg;

  typedef enum logic [1:0] {
    SRC_CONST   = 2'd0,
    SRC_ADDR    = 2'd1,
    SRC_PAYLOAD = 2'd2
  } src_e;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] len;
    src_e       src;
    logic [7:0] val;
  } step_t;

  localparam logic [7:0] OP_REG_WR  = 8'h20;
  localparam logic [7:0] OP_PL_WR   = 8'hA0;

  localparam logic [4:0] RG_CONFIG  = 5'h00;
  localparam logic [4:0] RG_AUTOACK = 5'h01;
  localparam logic [4:0] RG_PIPEEN  = 5'h02;
  localparam logic [4:0] RG_RETRY   = 5'h04;
  localparam logic [4:0] RG_CHAN    = 5'h05;
  localparam logic [4:0] RG_PHY     = 5'h06;
  localparam logic [4:0] RG_RXADR0  = 5'h0A;
  localparam logic [4:0] RG_TXADR   = 5'h10;
  localparam logic [4:0] RG_RXWID0  = 5'h11;

  function automatic logic [7:0] reg_wr(input logic [4:0] addr);
    return OP_REG_WR | {3'b000, addr};
  endfunction

  function automatic step_t mk_step(input logic [7:0] cmd, input logic [7:0] len,
                                    input src_e src, input logic [7:0] val);
    step_t s;
    s.cmd = cmd;
    s.len = len;
    s.src = src;
    s.val = val;
    return s;
  endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_byte_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic             active_q;
  logic             sclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_sh_q;
  logic [7:0]       rx_sh_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          tx_sh_q  <= tx_byte_i;
          cnt_q    <= '0;
          bit_q    <= '0;
        end
      end else if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        if (!sclk_q) begin
          sclk_q  <= 1'b1;
          rx_sh_q <= {rx_sh_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q   <= bit_q + 3'd1;
            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign sclk_o    = sclk_q;
  assign mosi_o    = tx_sh_q[7];
  assign done_o    = done_q;
  assign rx_byte_o = rx_sh_q;
endmodule

// File: rtl/cfg_step_table.sv
module cfg_step_table
  import radio_cfg_pkg::*;
#(
  parameter int         ADDR_LEN    = 5,
  parameter int         PAYLOAD_LEN = 32,
  parameter int         STEP_W      = 4
) (
  input  logic              mode_tx_i,
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o,
  output logic [STEP_W-1:0] count_o
);
  localparam logic [7:0] ALEN = 8'(ADDR_LEN);
  localparam logic [7:0] PLEN = 8'(PAYLOAD_LEN);

  always_comb begin
    step_o = mk_step(reg_wr(RG_CONFIG), 8'd1, SRC_CONST, 8'h00);
    if (mode_tx_i) begin
      count_o = STEP_W'(9);
      case (idx_i)
        STEP_W'(0): step_o = mk_step(reg_wr(RG_TXADR),   ALEN, SRC_ADDR,    8'h00);
        STEP_W'(1): step_o = mk_step(reg_wr(RG_RXADR0),  ALEN, SRC_ADDR,    8'h00);
        STEP_W'(2): step_o = mk_step(OP_PL_WR,           PLEN, SRC_PAYLOAD, 8'h00);
        STEP_W'(3): step_o = mk_step(reg_wr(RG_AUTOACK), 8'd1, SRC_CONST,   8'h01);
        STEP_W'(4): step_o = mk_step(reg_wr(RG_PIPEEN),  8'd1, SRC_CONST,   8'h01);
        STEP_W'(5): step_o = mk_step(reg_wr(RG_RETRY),   8'd1, SRC_CONST,   8'h0A);
        STEP_W'(6): step_o = mk_step(reg_wr(RG_CHAN),    8'd1, SRC_CONST,   8'h40);
        STEP_W'(7): step_o = mk_step(reg_wr(RG_PHY),     8'd1, SRC_CONST,   8'h07);
        default:    step_o = mk_step(reg_wr(RG_CONFIG),  8'd1, SRC_CONST,   8'h0E);
      endcase
    end else begin
      count_o = STEP_W'(7);
      case (idx_i)
        STEP_W'(0): step_o = mk_step(reg_wr(RG_RXADR0),  ALEN, SRC_ADDR,    8'h00);
        STEP_W'(1): step_o = mk_step(reg_wr(RG_AUTOACK), 8'd1, SRC_CONST,   8'h01);
        STEP_W'(2): step_o = mk_step(reg_wr(RG_PIPEEN),  8'd1, SRC_CONST,   8'h01);
        STEP_W'(3): step_o = mk_step(reg_wr(RG_CHAN),    8'd1, SRC_CONST,   8'h40);
        STEP_W'(4): step_o = mk_step(reg_wr(RG_RXWID0),  8'd1, SRC_CONST,   PLEN);
        STEP_W'(5): step_o = mk_step(reg_wr(RG_PHY),     8'd1, SRC_CONST,   8'h07);
        default:    step_o = mk_step(reg_wr(RG_CONFIG),  8'd1, SRC_CONST,   8'h0F);
      endcase
    end
  end
endmodule

// File: rtl/radio_cfg_seq.sv
module radio_cfg_seq
  import radio_cfg_pkg::*;
#(
  parameter int         CLK_DIV     = 4,
  parameter int         ADDR_LEN    = 5,
  parameter int         PAYLOAD_LEN = 32,
  parameter logic [7:0] ADDR_BYTE   = 8'hE7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       mode_tx_i,
  input  logic [7:0] pl_data_i,
  input  logic       pl_valid_i,
  output logic       pl_ready_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic       csn_o,
  output logic       ce_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] status_o,
  output logic       status_vld_o
);
  localparam int STEP_W = 4;
  localparam int GAP_W  = $clog2(CLK_DIV + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CLK_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_LOAD, S_SHIFT} state_e;

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        bidx_q;
  logic [GAP_W-1:0]  gap_q;
  logic              mode_q;
  logic              csn_q, ce_q, busy_q, done_q, svld_q;
  logic [7:0]        status_q;

  step_t             step;
  logic [STEP_W-1:0] step_cnt;
  logic              go;
  logic [7:0]        go_byte;
  logic              eng_done;
  logic [7:0]        eng_rx;

  cfg_step_table #(
    .ADDR_LEN   (ADDR_LEN),
    .PAYLOAD_LEN(PAYLOAD_LEN),
    .STEP_W     (STEP_W)
  ) u_table (
    .mode_tx_i(mode_q),
    .idx_i    (step_q),
    .step_o   (step),
    .count_o  (step_cnt)
  );

  spi_byte_engine #(.CLK_DIV(CLK_DIV)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (go),
    .tx_byte_i(go_byte),
    .miso_i   (miso_i),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .done_o   (eng_done),
    .rx_byte_o(eng_rx)
  );

  always_comb begin
    go         = 1'b0;
    go_byte    = step.cmd;
    pl_ready_o = 1'b0;
    if (state_q == S_LOAD) begin
      if (bidx_q == 8'd0) begin
        go = 1'b1;
      end else begin
        case (step.src)
          SRC_PAYLOAD: begin
            pl_ready_o = 1'b1;
            go         = pl_valid_i;
            go_byte    = pl_data_i;
          end
          SRC_ADDR: begin
            go      = 1'b1;
            go_byte = ADDR_BYTE;
          end
          default: begin
            go      = 1'b1;
            go_byte = step.val;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      step_q   <= '0;
      bidx_q   <= '0;
      gap_q    <= '0;
      mode_q   <= 1'b0;
      csn_q    <= 1'b1;
      ce_q     <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      svld_q   <= 1'b0;
      status_q <= '0;
    end else begin
      done_q <= 1'b0;
      svld_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            mode_q  <= mode_tx_i;
            busy_q  <= 1'b1;
            ce_q    <= 1'b0;
            step_q  <= '0;
            gap_q   <= '0;
            state_q <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_q == GAP_LAST) begin
            if (step_q == step_cnt) begin
              ce_q    <= 1'b1;
              done_q  <= 1'b1;
              busy_q  <= 1'b0;
              state_q <= S_IDLE;
            end else begin
              csn_q   <= 1'b0;
              bidx_q  <= '0;
              state_q <= S_LOAD;
            end
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        S_LOAD: begin
          if (go) state_q <= S_SHIFT;
        end
        default: begin
          if (eng_done) begin
            if (bidx_q == 8'd0) begin
              status_q <= eng_rx;
              svld_q   <= 1'b1;
            end
            if (bidx_q == step.len) begin
              csn_q   <= 1'b1;
              step_q  <= step_q + STEP_W'(1);
              gap_q   <= '0;
              state_q <= S_GAP;
            end else begin
              bidx_q  <= bidx_q + 8'd1;
              state_q <= S_LOAD;
            end
          end
        end
      endcase
    end
  end

  assign csn_o        = csn_q;
  assign ce_o         = ce_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign status_o     = status_q;
  assign status_vld_o = svld_q;
endmodule

// File: rtl/radio_cfg_seq_chk.sv
module radio_cfg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic ce_o,
  input logic csn_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic pl_ready_o,
  input logic status_vld_o
);
  p_sclk_idle_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csn_o |-> !sclk_o);

  p_mosi_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  p_csn_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn_o) |=> csn_o);

  p_ready_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready_o |-> (!csn_o && busy_o && !sclk_o));

  p_status_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status_vld_o |-> !csn_o);

  p_ce_low_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ce_o);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ce_o && !busy_o && csn_o && $past(busy_o)));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_until_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));
endmodule

bind radio_cfg_seq radio_cfg_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ce_o        (ce_o),
  .csn_o       (csn_o),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .pl_ready_o  (pl_ready_o),
  .status_vld_o(status_vld_o)
);

// File: tb/radio_cfg_seq_test.sv
`timescale 1ns/1ps
module radio_cfg_seq_test;
  localparam int CLK_DIV = 4;
  localparam int TCK     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, mode_tx_i = 1'b0;
  logic [7:0] pl_data_i = 8'h00;
  logic pl_valid_i = 1'b0;
  logic miso_i = 1'b0;
  logic pl_ready_o, sclk_o, mosi_o, csn_o, ce_o, busy_o, done_o, status_vld_o;
  logic [7:0] status_o;

  always #2 clk = ~clk;

  radio_cfg_seq #(.CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_tx_i(mode_tx_i),
    .pl_data_i(pl_data_i), .pl_valid_i(pl_valid_i), .pl_ready_o(pl_ready_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .csn_o(csn_o),
    .ce_o(ce_o), .busy_o(busy_o), .done_o(done_o),
    .status_o(status_o), .status_vld_o(status_vld_o)
  );

  // Expected transactions: transmit profile (0..8), then receive profile (9..15).
  localparam logic [7:0] EXP_CMD [16] = '{8'h30, 8'h2A, 8'hA0, 8'h21, 8'h22, 8'h24, 8'h25, 8'h26, 8'h20,
                                          8'h2A, 8'h21, 8'h22, 8'h25, 8'h31, 8'h26, 8'h20};
  localparam int         EXP_LEN [16] = '{5, 5, 32, 1, 1, 1, 1, 1, 1,
                                          5, 1, 1, 1, 1, 1, 1};
  localparam logic [7:0] EXP_VAL [16] = '{8'hE7, 8'hE7, 8'h00, 8'h01, 8'h01, 8'h0A, 8'h40, 8'h07, 8'h0E,
                                          8'hE7, 8'h01, 8'h01, 8'h40, 8'h20, 8'h07, 8'h0F};

  int checks = 0, errors = 0;
  bit finished = 0;

  // Radio model
  logic [7:0] rec [16][40];
  int rec_len [16];
  int rec_n = 0, bcnt = 0, bitn = 0;
  logic [7:0] sh = 8'h00, st_out = 8'h00;
  logic [7:0] st_rec [16];
  int st_n = 0;
  int per_bad = 0, gap_bad = 0, ce_bad = 0, done_n = 0;
  time last_rise = 0, csn_rise_t = 0;
  bit have_rise = 0;

  always @(negedge csn_o) begin
    st_out = 8'h40 + 8'(rec_n);
    miso_i = st_out[7];
    bitn = 0;
    bcnt = 0;
    if (ce_o) ce_bad++;
    if (have_rise && ($time - csn_rise_t) < CLK_DIV * TCK) gap_bad++;
  end

  always @(posedge sclk_o) if (!csn_o) begin
    if (bitn != 0 && ($time - last_rise) != CLK_DIV * TCK) per_bad++;
    last_rise = $time;
    sh = {sh[6:0], mosi_o};
    bitn++;
    if (bitn == 8) begin
      if (rec_n < 16 && bcnt < 40) rec[rec_n][bcnt] = sh;
      bcnt++;
      bitn = 0;
    end
  end

  always @(negedge sclk_o) if (!csn_o) begin
    st_out = {st_out[6:0], 1'b0};
    miso_i = st_out[7];
  end

  always @(posedge csn_o) if (bcnt > 0) begin
    if (rec_n < 16) rec_len[rec_n] = bcnt;
    rec_n++;
    bcnt = 0;
    csn_rise_t = $time;
    have_rise = 1;
  end

  // Payload stream source with periodic stalls
  int pl_idx = 0, stall = 0;
  always @(negedge clk) begin
    pl_valid_i = (stall % 3) != 0;
    pl_data_i  = 8'h10 + 8'(pl_idx);
    stall++;
    if (pl_valid_i && pl_ready_o) pl_idx++;
    if (status_vld_o) begin
      if (st_n < 16) st_rec[st_n] = status_o;
      st_n++;
    end
    if (busy_o && ce_o) ce_bad++;
    if (done_o) begin
      done_n++;
      if (!ce_o || busy_o) ce_bad++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cfg(input bit tx);
    int base = tx ? 0 : 9;
    int n = tx ? 9 : 7;
    int wait_n = 0;
    rec_n = 0; st_n = 0; pl_idx = 0; done_n = 0;
    per_bad = 0; gap_bad = 0; ce_bad = 0; have_rise = 0;
    @(negedge clk);
    mode_tx_i = tx; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1 && ce_o == 1'b0, "R11", "busy/ce after start", {busy_o, ce_o}, 2);
    while (!done_o && wait_n < 20000) begin
      @(negedge clk);
      wait_n++;
      if (tx && wait_n == 300) begin
        mode_tx_i = 1'b0; start_i = 1'b1;   // R12: must be ignored
      end else begin
        start_i = 1'b0;
      end
    end
    repeat (20) @(negedge clk);
    check(rec_n == n, tx ? "R6 R12" : "R7", "transaction count", rec_n, n);
    check(done_n == 1, "R12", "done pulses", done_n, 1);
    for (int t = 0; t < n && t < rec_n; t++) begin
      int e = base + t;
      int bad = -1;
      logic [7:0] want = 8'h00, got = 8'h00;
      if (rec_len[t] != EXP_LEN[e] + 1) bad = 99;
      else if (rec[t][0] != EXP_CMD[e]) begin bad = 0; got = rec[t][0]; want = EXP_CMD[e]; end
      else for (int k = 1; k <= EXP_LEN[e]; k++) begin
        logic [7:0] w = (EXP_CMD[e] == 8'hA0) ? 8'(8'h10 + k - 1) : EXP_VAL[e];
        if (bad < 0 && rec[t][k] != w) begin bad = k; got = rec[t][k]; want = w; end
      end
      if (bad == 99)
        check(1'b0, "R4 R8 R9", $sformatf("txn %0d length", t), rec_len[t], EXP_LEN[e] + 1);
      else
        check(bad < 0, (EXP_CMD[e] == 8'hA0) ? "R9" : (tx ? "R5 R6 R8" : "R5 R7 R8"),
              $sformatf("txn %0d byte %0d", t, bad), got, want);
    end
    check(st_n == n, "R10", "status strobes", st_n, n);
    for (int t = 0; t < n && t < st_n; t++)
      check(st_rec[t] == 8'(8'h40 + t), "R10", $sformatf("status %0d", t), st_rec[t], 8'h40 + t);
    check(per_bad == 0, "R3 R2", "sclk period violations", per_bad, 0);
    check(gap_bad == 0, "R4", "csn gap violations", gap_bad, 0);
    check(ce_bad == 0 && ce_o == 1'b1 && busy_o == 1'b0, "R11", "ce/done violations", ce_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(csn_o == 1'b1, "R1", "csn", csn_o, 1);
    check(sclk_o == 1'b0, "R1", "sclk", sclk_o, 0);
    check(ce_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R1", "ce/busy/done", {ce_o, busy_o, done_o}, 0);
    check(pl_ready_o == 1'b0 && status_vld_o == 1'b0, "R1", "ready/svld", {pl_ready_o, status_vld_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(csn_o == 1'b1 && ce_o == 1'b0, "R1", "idle after reset", {csn_o, ce_o}, 2);
    run_cfg(1'b1);
    run_cfg(1'b0);
    // Back-to-back: transmit again after receive
    run_cfg(1'b1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * TCK);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule